// File: doc/BRIEF.md
# SDR SDRAM Read/Write Data Path

This block is the data side of a single-data-rate SDRAM controller. The command logic tells it when a read burst begins, how long the burst is, and when the burst is cut short. The block keeps its own record of the beats in flight. It samples the DQ bus the programmed CAS latency after each beat's command edge and presents the captured word with a valid strobe and per-byte enables. Bytes that the read mask turned to high impedance come back zeroed and disabled.

On writes the command logic presents data and byte masks together with a write-beat flag. The block drives them onto the pins in the same cycle. It withholds the bus drive whenever returning read data is due on that edge or the next one. When a precharge or burst stop ends a read, the beats already issued still drain. This naturally leaves CAS latency minus one valid beats after the interrupting edge.

Top module: `sdr_dpath`

## Requirements
- R1: While rst_n is low, rd_valid, rd_data, rd_be and dq_oe are all zero, and no read beat is pending once reset releases.
- R2: A read beat issued on edge k is captured from dq_i on edge k+CL, where cas_lat encodes CL directly (1, 2 or 3). rd_valid, rd_data and rd_be then hold it for the one cycle after that edge.
- R3: rd_cmd with bl_code = 0, 1, 2 or 3 starts a burst of 1, 2, 4 or 8 read beats on consecutive edges, the first on the edge that samples rd_cmd.
- R4: A new rd_cmd while a burst is running abandons the remaining beats of the old burst and starts the new burst on that edge.
- R5: stop sampled on edge t (without rd_cmd) cancels the beat of edge t and all later beats of the burst, so exactly CL-1 valid words follow edge t.
- R6: With wr_beat high and no read data due, dq_oe is 1, dq_o equals wr_data and dqm_o equals wr_mask in that same cycle (write mask latency 0). Otherwise dq_oe is 0 and dqm_o equals rd_mask.
- R7: Bit j of dqm_o sampled on edge e masks byte j (bits 8j+7..8j) of the word captured on edge e+2: that byte of rd_data reads 0 and rd_be[j] is 0.
- R8: dq_oe is held low on any edge where read data is captured and on the edge just before it, even if wr_beat is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat | input | 2 | CAS latency in clocks, 1 to 3 |
| rd_cmd | input | 1 | Read command issued on this edge |
| bl_code | input | 2 | Burst length code, length = 2^bl_code |
| stop | input | 1 | Precharge or burst stop interrupting the read |
| rd_mask | input | 4 | Byte mask to place on DQM outside writes |
| wr_beat | input | 1 | Write data beat on this edge |
| wr_data | input | 32 | Write data |
| wr_mask | input | 4 | Write byte mask, 1 = byte not written |
| dq_i | input | 32 | DQ bus input |
| dq_o | output | 32 | DQ bus output value |
| dq_oe | output | 1 | DQ output enable |
| dqm_o | output | 4 | DQM pins |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | 32 | Captured read word, masked bytes zero |
| rd_be | output | 4 | Byte enables of the captured word |

## Verification
Each read beat is due exactly CL edges after its command edge. Its byte mask is the DQM value from two edges before the capture. The driver task therefore pushes, per beat, the due edge, the word the bench's bus model places on dq_i at that edge, and the enables derived from the mask pattern of edge due-2. The monitor compares at the falling edge after each capture and flags a missing or early word against the due edge. Write outputs are combinational with the beat, so they are checked shortly after inputs change within the same cycle. The stop case counts valid words strictly after the stop edge against CL-1.

// File: rtl/sdr_dpath.sv
module sdr_dpath #(
  parameter int DW  = 32,
  parameter int BW  = 8,
  parameter int NB  = DW / BW,
  parameter int LBW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cas_lat,
  input  logic          rd_cmd,
  input  logic [LBW-1:0] bl_code,
  input  logic          stop,
  input  logic [NB-1:0] rd_mask,
  input  logic          wr_beat,
  input  logic [DW-1:0] wr_data,
  input  logic [NB-1:0] wr_mask,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic [NB-1:0] dqm_o,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [NB-1:0] rd_be
);

  localparam int MAXCL = 3;
  localparam int CW    = (1 << LBW) - 1;

  logic [CW-1:0]    cnt;
  logic             beat;
  logic [MAXCL:1]   vp;
  logic [MAXCL:0]   lv;
  logic             due_now, due_next;
  logic [NB-1:0]    m1, m2;
  logic [DW-1:0]    keep;

  assign beat     = rd_cmd | ((cnt != '0) & ~stop);
  assign lv       = {vp, beat};
  assign due_now  = lv[cas_lat];
  assign due_next = lv[cas_lat - 2'd1];

  assign dq_oe = wr_beat & ~due_now & ~due_next;
  assign dq_o  = wr_data;
  assign dqm_o = dq_oe ? wr_mask : rd_mask;

  for (genvar b = 0; b < NB; b++) begin : g_keep
    assign keep[b*BW +: BW] = {BW{~m2[b]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      vp  <= '0;
    end else begin
      vp <= lv[MAXCL-1:0];
      if (rd_cmd)          cnt <= CW'((1 << bl_code) - 1);
      else if (stop)       cnt <= '0;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1       <= '0;
      m2       <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_be    <= '0;
    end else begin
      m1       <= dqm_o;
      m2       <= m1;
      rd_valid <= due_now;
      if (due_now) begin
        rd_data <= dq_i & keep;
        rd_be   <= ~m2;
      end
    end
  end

  p_cl_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_lat != 2'd0);

  p_lat1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd1 && beat) |=> ##1 rd_valid);

  p_lat2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd2 && beat) |=> ##2 rd_valid);

  p_lat3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd3 && beat) |=> ##3 rd_valid);

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !rd_cmd) |=> (beat == rd_cmd));

  p_rmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_be == ~$past(dqm_o, 3));

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!$past(dq_oe) && !$past(dq_oe, 2)));

endmodule

// File: tb/sdr_dpath_test.sv
`timescale 1ns/1ps
module sdr_dpath_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cas_lat = 2'd1;
  logic        rd_cmd = 1'b0;
  logic [1:0]  bl_code = 2'd0;
  logic        stop = 1'b0;
  logic [3:0]  rd_mask;
  logic        wr_beat = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_mask = '0;
  logic [31:0] dq_i;
  logic [31:0] dq_o;
  logic        dq_oe;
  logic [3:0]  dqm_o;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  rd_be;

  int checks = 0;
  int errors = 0;
  int pc = 0;
  int cl = 1;
  bit mask_on = 1'b0;

  typedef struct { int due; logic [31:0] d; logic [3:0] be; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) pc <= pc + 1;

  function automatic logic [31:0] pat(int n);
    return (32'(n) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] expand(logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  assign dq_i    = pat(pc + 1);
  assign rd_mask = mask_on ? 4'(pc + 1) : 4'h0;

  sdr_dpath uut (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_cmd(rd_cmd),
    .bl_code(bl_code), .stop(stop), .rd_mask(rd_mask), .wr_beat(wr_beat),
    .wr_data(wr_data), .wr_mask(wr_mask), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .dqm_o(dqm_o), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_be(rd_be)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at edge %0d", tag, act, exp, pc);
    end
  endtask

  function automatic void push(int e);
    exp_t x;
    logic [3:0] m;
    m = mask_on ? 4'(e - 2) : 4'h0;
    x.due = e;
    x.be  = ~m;
    x.d   = pat(e) & expand(~m);
    q.push_back(x);
  endfunction

  // monitor: R2, R3, R4, R7 via due edge and word contents
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].due < pc) begin
        chk(1'b0, "R2 missing read word", 32'(pc), 32'(q[0].due));
        void'(q.pop_front());
      end
      if (rd_valid) begin
        if (q.size() > 0 && q[0].due == pc) begin
          chk(rd_data == q[0].d, "R2/R3/R7 rd_data", rd_data, q[0].d);
          chk(rd_be == q[0].be, "R7 rd_be", 32'(rd_be), 32'(q[0].be));
          void'(q.pop_front());
        end else begin
          chk(1'b0, "R2 unexpected read word", 32'(pc), q.size() > 0 ? 32'(q[0].due) : 32'hFFFFFFFF);
        end
      end
    end
  end

  task automatic setcl(input int c);
    repeat (6) @(negedge clk);
    cl = c;
    cas_lat = 2'(c);
  endtask

  task automatic rd(input int code, input int s);
    int k, n, last, cntv;
    @(negedge clk);
    k = pc + 1;
    rd_cmd = 1'b1;
    bl_code = 2'(code);
    n = 1 << code;
    last = (s > 0 && s < n) ? s : n;
    for (int j = 0; j < last; j++) push(k + j + cl);
    @(negedge clk);
    rd_cmd = 1'b0;
    if (s > 0) begin
      repeat (s - 1) @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      cntv = 0;
      for (int i = 0; i < cl + 3; i++) begin
        if (pc > k + s && rd_valid) cntv++;
        @(negedge clk);
      end
      chk(cntv == cl - 1, "R5 words after stop", 32'(cntv), 32'(cl - 1));
    end
    repeat (n + 4) @(negedge clk);
  endtask

  task automatic wr_once(input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    wr_beat = 1'b1; wr_data = d; wr_mask = m;
    #1;
    chk(dq_oe == 1'b1, "R6 dq_oe on write", 32'(dq_oe), 32'd1);
    chk(dq_o == d, "R6 dq_o", dq_o, d);
    chk(dqm_o == m, "R6 dqm_o write mask", 32'(dqm_o), 32'(m));
    @(negedge clk);
    wr_beat = 1'b0;
    #1;
    chk(dq_oe == 1'b0, "R6 dq_oe idle", 32'(dq_oe), 32'd0);
    chk(dqm_o == rd_mask, "R6 dqm_o idle", 32'(dqm_o), 32'(rd_mask));
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k;
    repeat (4) @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", 32'(rd_valid), 32'd0);
    chk(dq_oe == 1'b0, "R1 dq_oe in reset", 32'(dq_oe), 32'd0);
    chk(rd_data == 32'd0, "R1 rd_data in reset", rd_data, 32'd0);
    chk(rd_be == 4'd0, "R1 rd_be in reset", 32'(rd_be), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R1 nothing pending after reset", 32'(rd_valid), 32'd0);

    // R2 and R3 over every latency and burst length; R7 with a moving mask
    for (int c = 1; c <= 3; c++) begin
      setcl(c);
      mask_on = 1'b0;
      for (int b = 0; b < 4; b++) rd(b, 0);
      mask_on = 1'b1;
      rd(1, 0);
      rd(3, 0);
      mask_on = 1'b0;
    end

    // R4 back-to-back: second command cuts the first burst after two beats
    setcl(2);
    @(negedge clk);
    k = pc + 1;
    rd_cmd = 1'b1; bl_code = 2'd3;
    push(k + cl); push(k + 1 + cl);
    @(negedge clk);
    rd_cmd = 1'b0;
    @(negedge clk);
    rd_cmd = 1'b1; bl_code = 2'd1;
    push(k + 2 + cl); push(k + 3 + cl);
    @(negedge clk);
    rd_cmd = 1'b0;
    repeat (12) @(negedge clk);

    // R5 interrupted bursts at each latency
    setcl(3); rd(3, 4);
    setcl(2); rd(3, 4);
    setcl(1); rd(3, 4);

    // R6 writes with no read traffic
    setcl(2);
    wr_once(32'hDEADBEEF, 4'b0000);
    wr_once(32'h01234567, 4'b1010);
    wr_once(32'hFFFF0000, 4'b0101);

    // R8 contention guard at CL=3: read at k, data due at k+3
    setcl(3);
    @(negedge clk);
    k = pc + 1;
    rd_cmd = 1'b1; bl_code = 2'd0;
    push(k + 3);
    @(negedge clk);
    rd_cmd = 1'b0; wr_beat = 1'b1; wr_data = 32'hA5A5A5A5; wr_mask = 4'h0;
    #1 chk(dq_oe == 1'b1, "R8 write two edges before data", 32'(dq_oe), 32'd1);
    @(negedge clk);
    wr_mask = 4'hF;
    #1 chk(dq_oe == 1'b0, "R8 write one edge before data", 32'(dq_oe), 32'd0);
    chk(dqm_o == 4'h0, "R8 dqm_o when held off", 32'(dqm_o), 32'd0);
    @(negedge clk);
    #1 chk(dq_oe == 1'b0, "R8 write on capture edge", 32'(dq_oe), 32'd0);
    @(negedge clk);
    #1 chk(dq_oe == 1'b1, "R8 write after capture", 32'(dq_oe), 32'd1);
    @(negedge clk);
    wr_beat = 1'b0; wr_mask = 4'h0;

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R2 all expected words seen", 32'(q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule